// File: doc/BRIEF.md
# 100 Mbit/s Transmit Code-Group Encoder

This block sits between a nibble-wide MAC transmit stream and a 100 Mbit/s serial path. Each clock it turns the incoming nibble into a 5-bit code group. It also reshapes the frame. The first two nibbles of a frame become a start delimiter. An end delimiter is appended once the frame-enable input drops. Idle code groups fill every gap between frames. A nibble flagged as errored is replaced by the error code group. A bypass input turns off all of this and passes 5-bit words straight to the output.

The output is registered and carries one code group on every clock, with no output handshake. The input side has one form of back-pressure: `tx_ready`. It is low for exactly one cycle, the cycle in which the second end-delimiter symbol goes out. While `tx_ready` is low, the source must hold `tx_en`, `tx_er` and `txd` unchanged. A nibble is taken on a rising clock edge only while `tx_ready` is high. If a new frame is already waiting when the end delimiter finishes, it starts on the following cycle. This means the two delimiter symbols are never cut short.

Top module: `pcs100_tx_encoder`

## Requirements
- R1: While `rst_n` is low, `code_out` is 11111 and `tx_ready` is 1.
- R2: When no frame is in progress and `tx_en` is low, `code_out` is the idle code 11111 on every cycle, whatever `txd` and `tx_er` hold.
- R3: The first two accepted cycles of a frame (the cycle `tx_en` is first seen high, and the next one) produce 11000 and then 10001. The nibble values and `tx_er` are ignored in those two cycles, and the second symbol is sent even if `tx_en` has already dropped.
- R4: Each later nibble accepted with `tx_en` high and `tx_er` low appears on `code_out` one clock after the edge that samples it. The nibble-to-code mapping, from 0 to F, is: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: In the data phase, a nibble sampled with both `tx_en` and `tx_er` high produces 00100 in place of its code.
- R6: The first data-phase cycle with `tx_en` low produces 01101, the next cycle produces 00111, and idle follows.
- R7: `tx_ready` is low during the cycle in which 00111 is produced, and only then. A frame held by the source during that cycle starts with 11000 on the next cycle.
- R8: While `bypass` is high, `code_out` one clock later equals {`tx_er`, `txd[3:0]`}, with `tx_er` as bit 4. No delimiter or error code is inserted, and the frame state returns to idle, so the next frame after bypass opens with 11000.
- R9: `tx_ready` is 1 whenever `bypass` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the MAC side |
| tx_er | input | 1 | Error flag; fifth raw bit in bypass |
| txd | input | 4 | Transmit nibble |
| bypass | input | 1 | Pass 5-bit raw words unaltered |
| tx_ready | output | 1 | Input accepted on this edge when high |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
Several kinds of frame are driven. A long frame walks all sixteen nibble values and exposes any wrong table entry. A one-nibble frame shows that the start symbol pair is sent in full even when the enable drops early. A frame with error flags, placed both on a delimiter cycle and on a data cycle, separates correct error substitution from substitution in the wrong phase. In the back-to-back case, the next frame is raised during the end delimiter, which tells a correct stall apart from a truncated or skipped delimiter. Bypass runs use raw words that look like delimiters, and also switch bypass on in the middle of a frame. These show that no framing leaks into bypass and that framing restarts cleanly once bypass is released.

// File: rtl/pcs100_pkg.sv
package pcs100_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] CG_IDLE  = 5'b11111;
  localparam logic [CODE_W-1:0] CG_SOS1  = 5'b11000;
  localparam logic [CODE_W-1:0] CG_SOS2  = 5'b10001;
  localparam logic [CODE_W-1:0] CG_EOS1  = 5'b01101;
  localparam logic [CODE_W-1:0] CG_EOS2  = 5'b00111;
  localparam logic [CODE_W-1:0] CG_ERROR = 5'b00100;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SOS2,
    FR_DATA,
    FR_EOS2
  } frame_st_t;

  typedef enum logic [2:0] {
    PICK_IDLE,
    PICK_SOS1,
    PICK_SOS2,
    PICK_DATA,
    PICK_ERROR,
    PICK_EOS1,
    PICK_EOS2,
    PICK_RAW
  } pick_t;
endpackage

// File: rtl/pcs100_nibble_map.sv
module pcs100_nibble_map
  import pcs100_pkg::*;
(
  input  logic [NIB_W-1:0]  nib,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    unique case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end
endmodule

// File: rtl/pcs100_frame_fsm.sv
module pcs100_frame_fsm
  import pcs100_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  input  logic      tx_er,
  input  logic      bypass,
  output frame_st_t state,
  output pick_t     pick,
  output logic      ready
);
  frame_st_t nxt;

  always_comb begin
    nxt  = state;
    pick = PICK_IDLE;
    if (bypass) begin
      pick = PICK_RAW;
      nxt  = FR_IDLE;
    end else begin
      unique case (state)
        FR_IDLE: begin
          if (tx_en) begin
            pick = PICK_SOS1;
            nxt  = FR_SOS2;
          end
        end
        FR_SOS2: begin
          pick = PICK_SOS2;
          nxt  = FR_DATA;
        end
        FR_DATA: begin
          if (tx_en) begin
            pick = tx_er ? PICK_ERROR : PICK_DATA;
          end else begin
            pick = PICK_EOS1;
            nxt  = FR_EOS2;
          end
        end
        default: begin
          pick = PICK_EOS2;
          nxt  = FR_IDLE;
        end
      endcase
    end
  end

  assign ready = bypass || (state != FR_EOS2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FR_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pcs100_code_reg.sv
module pcs100_code_reg
  import pcs100_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pick_t             pick,
  input  logic [CODE_W-1:0] data_code,
  input  logic [CODE_W-1:0] raw_word,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    unique case (pick)
      PICK_SOS1:  code_d = CG_SOS1;
      PICK_SOS2:  code_d = CG_SOS2;
      PICK_DATA:  code_d = data_code;
      PICK_ERROR: code_d = CG_ERROR;
      PICK_EOS1:  code_d = CG_EOS1;
      PICK_EOS2:  code_d = CG_EOS2;
      PICK_RAW:   code_d = raw_word;
      default:    code_d = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= CG_IDLE;
    else        code_q <= code_d;
  end
endmodule

// File: rtl/pcs100_tx_encoder.sv
module pcs100_tx_encoder
  import pcs100_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  txd,
  input  logic              bypass,
  output logic              tx_ready,
  output logic [CODE_W-1:0] code_out
);
  frame_st_t         st;
  pick_t             pick;
  logic [CODE_W-1:0] mapped;
  logic [CODE_W-1:0] raw_word;

  assign raw_word = {tx_er, txd};

  pcs100_nibble_map u_map (
    .nib  (txd),
    .code (mapped)
  );

  pcs100_frame_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .tx_er  (tx_er),
    .bypass (bypass),
    .state  (st),
    .pick   (pick),
    .ready  (tx_ready)
  );

  pcs100_code_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (pick),
    .data_code (mapped),
    .raw_word  (raw_word),
    .code_q    (code_out)
  );

  // R2: idle fills the gap
  a_r2_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st == FR_IDLE && !tx_en) |=> code_out == CG_IDLE);

  // R3: start symbol pair
  a_r3_sos_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st == FR_IDLE && tx_en) |=> code_out == CG_SOS1);
  a_r3_sos_second: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st == FR_SOS2) |=> code_out == CG_SOS2);

  // R5: error substitution in data phase
  a_r5_err_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st == FR_DATA && tx_en && tx_er) |=> code_out == CG_ERROR);

  // R6: end delimiter
  a_r6_eos_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st == FR_DATA && !tx_en) |=> code_out == CG_EOS1);

  // R7: stall only while the second end symbol is chosen
  a_r7_stall_on_eos2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready) |=> code_out == CG_EOS2);

  // R8: bypass is transparent
  a_r8_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> code_out == $past({tx_er, txd}));

  // R9: no stall in bypass
  a_r9_ready_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> tx_ready);
endmodule

// File: tb/pcs100_tx_encoder_test.sv
module pcs100_tx_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, tx_er, bypass;
  logic [3:0] txd;
  logic       tx_ready;
  logic [4:0] code_out;
  logic       rdy_seen;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pcs100_tx_encoder uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
    .txd(txd), .bypass(bypass), .tx_ready(tx_ready), .code_out(code_out)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d, input logic byp);
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d; bypass = byp;
    #1 rdy_seen = tx_ready;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0; bypass = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 code in reset", code_out, 5'b11111);
    chk("R1 ready in reset", {4'b0, tx_ready}, 5'd1);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) begin
      step(1'b0, i[0], 4'(i * 5 + 3), 1'b0);
      chk("R2 idle fill", code_out, 5'b11111);
    end
  endtask

  task automatic t_frame();
    step(1'b1, 1'b0, 4'h5, 1'b0); chk("R3 first start symbol", code_out, 5'b11000);
    step(1'b1, 1'b0, 4'h5, 1'b0); chk("R3 second start symbol", code_out, 5'b10001);
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 1'b0, 4'(v), 1'b0);
      chk($sformatf("R4 nibble %0h", v), code_out, enc(4'(v)));
    end
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 first end symbol", code_out, 5'b01101);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 second end symbol", code_out, 5'b00111);
    chk("R7 ready low on second end symbol", {4'b0, rdy_seen}, 5'd0);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 idle after frame", code_out, 5'b11111);
    chk("R7 ready back high", {4'b0, rdy_seen}, 5'd1);
  endtask

  task automatic t_error();
    step(1'b1, 1'b1, 4'hA, 1'b0); chk("R5 error ignored on start symbol", code_out, 5'b11000);
    step(1'b1, 1'b0, 4'h5, 1'b0); chk("R3 second start symbol", code_out, 5'b10001);
    step(1'b1, 1'b1, 4'h3, 1'b0); chk("R5 error code", code_out, 5'b00100);
    step(1'b1, 1'b0, 4'h4, 1'b0); chk("R4 data after error", code_out, enc(4'h4));
    step(1'b0, 1'b1, 4'h0, 1'b0); chk("R6 first end symbol", code_out, 5'b01101);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 second end symbol", code_out, 5'b00111);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R2 idle", code_out, 5'b11111);
  endtask

  task automatic t_back_to_back();
    step(1'b1, 1'b0, 4'h5, 1'b0); chk("R3 start", code_out, 5'b11000);
    step(1'b1, 1'b0, 4'h5, 1'b0); chk("R3 start 2", code_out, 5'b10001);
    step(1'b1, 1'b0, 4'hD, 1'b0); chk("R4 data", code_out, enc(4'hD));
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 end 1", code_out, 5'b01101);
    step(1'b1, 1'b0, 4'h9, 1'b0); chk("R7 end 2 while next frame waits", code_out, 5'b00111);
    chk("R7 stall seen", {4'b0, rdy_seen}, 5'd0);
    step(1'b1, 1'b0, 4'h9, 1'b0); chk("R7 held frame opens", code_out, 5'b11000);
    chk("R7 ready high", {4'b0, rdy_seen}, 5'd1);
    step(1'b1, 1'b0, 4'h2, 1'b0); chk("R3 start 2 of next", code_out, 5'b10001);
    step(1'b1, 1'b0, 4'h7, 1'b0); chk("R4 data of next", code_out, enc(4'h7));
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 end 1", code_out, 5'b01101);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 end 2", code_out, 5'b00111);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R2 idle", code_out, 5'b11111);
  endtask

  task automatic t_short();
    step(1'b1, 1'b0, 4'h1, 1'b0); chk("R3 short start", code_out, 5'b11000);
    step(1'b0, 1'b0, 4'h1, 1'b0); chk("R3 second symbol after early drop", code_out, 5'b10001);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 short end 1", code_out, 5'b01101);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 short end 2", code_out, 5'b00111);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R2 idle", code_out, 5'b11111);
  endtask

  task automatic t_bypass();
    step(1'b0, 1'b1, 4'h3, 1'b1); chk("R8 raw word", code_out, 5'b10011);
    chk("R9 ready in bypass", {4'b0, rdy_seen}, 5'd1);
    step(1'b1, 1'b0, 4'hD, 1'b1); chk("R8 raw end-like word", code_out, 5'b01101);
    step(1'b1, 1'b0, 4'h0, 1'b1); chk("R8 no delimiter follows", code_out, 5'b00000);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R2 idle after bypass", code_out, 5'b11111);
    step(1'b1, 1'b0, 4'h5, 1'b0); chk("R3 start", code_out, 5'b11000);
    step(1'b1, 1'b1, 4'hF, 1'b1); chk("R8 bypass mid-frame", code_out, 5'b11111);
    chk("R9 ready in bypass mid-frame", {4'b0, rdy_seen}, 5'd1);
    step(1'b1, 1'b0, 4'h5, 1'b0); chk("R8 frame restarts after bypass", code_out, 5'b11000);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R3 second start", code_out, 5'b10001);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 end 1", code_out, 5'b01101);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R6 end 2", code_out, 5'b00111);
    step(1'b0, 1'b0, 4'h0, 1'b0); chk("R2 idle", code_out, 5'b11111);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_frame();
    t_error();
    t_back_to_back();
    t_short();
    t_bypass();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule